// File: doc/BRIEF.md
# Chip-Select Address Region Decoder

This block maps a system byte address onto one of eight chip-select regions. Each select is described by a 12-bit configuration word that holds a 6-bit region base, a 4-bit size mask and an enable bit. On every strobed access, the decoder compares the upper address bits with each enabled region. It then raises the select of the matching region and reports the address relative to the start of that region.

Each configuration word is checked for legality on every cycle. The mask must be a thermometer code that grows downward from its top bit. The base may not set any low bit that the mask leaves uncovered. An enabled select that breaks either rule raises its error flag and never asserts. When legal regions overlap, the lowest-numbered select takes the access. All outputs are registered: results appear one clock after the inputs that produce them. A configuration change therefore takes effect on the next strobe without any separate update step.

Top module: `cs_region_decoder`

## Requirements
- R1: While `rst` is high and on the first edge after it, `cs_sel`, `cs_err` and `offset` are all zero.
- R2: A clock edge with `strobe` low makes `cs_sel` zero and `offset` zero on the next cycle.
- R3: Configuration word layout: bits 5:0 are the base, bit 6 is the enable bit, bits 11:8 are the mask, and bit 7 is ignored. Select i matches when `addr[29:28]` equals base[5:4] and `addr[27:24]` AND mask equals base[3:0] AND mask. A strobed match drives `cs_sel[i]` one cycle later.
- R4: A select whose enable bit is 0 never asserts and never flags an error, whatever its mask and base.
- R5: An enabled select whose mask is not 4'b1000, 4'b1100, 4'b1110 or 4'b1111 sets its `cs_err` bit on the next cycle and does not assert.
- R6: An enabled select whose base[3:0] has a 1 in a position where its mask is 0 sets its `cs_err` bit and does not assert.
- R7: The region size is 16 MiB for mask 4'b1111, 32 MiB for 4'b1110, 64 MiB for 4'b1100 and 128 MiB for 4'b1000. `offset` is `addr[27:0]` with every bit at or above the region size cleared, so `offset[27]` is always 0.
- R8: When several legal regions match, only the lowest-numbered one asserts. `cs_sel` is always one-hot or all zero.
- R9: A configuration word change applies to the very next strobed access, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Access valid this cycle |
| addr | input | 30 | System byte address |
| cfg_words | input | 96 | Eight 12-bit configuration words; select i at bits 12*i+11:12*i |
| cs_sel | output | 8 | Registered one-hot chip-select |
| offset | output | 28 | Registered region-local offset of the granted access |
| cs_err | output | 8 | Registered per-select configuration error flags |

## Verification
The assertions assume that the configuration words are stable during the edge that samples them. They also assume that each word follows the stated field layout, with the reserved bit allowed to take any value. The assertions make no assumption about overlap between regions. The stimulus changes configuration and address only on falling edges, which keeps every input steady across the sampling edge. Overlap, disabled words carrying illegal fields, and illegal masks are applied on purpose, so that the priority and refusal paths are reached inside those assumptions.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

  // Fixed field layout of one configuration word
  localparam int CFG_W  = 12;
  localparam int BASE_W = 6;
  localparam int MASK_W = 4;

  typedef struct packed {
    logic [MASK_W-1:0] mask;   // 11:8
    logic              rsvd;   // 7
    logic              enable; // 6
    logic [BASE_W-1:0] base;   // 5:0
  } cs_cfg_t;

  // Legal masks fill from the top bit downward: 1000, 1100, 1110, 1111
  function automatic logic mask_legal(input logic [MASK_W-1:0] m);
    logic ok;
    ok = m[MASK_W-1];
    for (int k = 0; k < MASK_W-1; k++) begin
      if (m[k] && !m[k+1]) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/cs_region_check.sv
module cs_region_check
  import cs_dec_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [BASE_W-1:0] addr_hi,
  output logic              hit,
  output logic              err,
  output logic [MASK_W-1:0] mask
);

  localparam int TOP_W = BASE_W - MASK_W;

  cs_cfg_t cfg;
  logic    unused_rsvd;
  logic    bad_mask;
  logic    bad_base;
  logic    top_eq;
  logic    low_eq;

  assign cfg         = cs_cfg_t'(cfg_word);
  assign unused_rsvd = cfg.rsvd;
  assign mask        = cfg.mask;

  always_comb begin
    bad_mask = !mask_legal(cfg.mask);
    bad_base = |(cfg.base[MASK_W-1:0] & ~cfg.mask);
    err      = cfg.enable && (bad_mask || bad_base);
    top_eq   = addr_hi[BASE_W-1:MASK_W] == cfg.base[BASE_W-1:MASK_W];
    low_eq   = (addr_hi[MASK_W-1:0] & cfg.mask) == (cfg.base[MASK_W-1:0] & cfg.mask);
    hit      = cfg.enable && !err && top_eq && low_eq;
  end

  if (TOP_W < 1) begin : g_bad_layout
    initial $error("base must be wider than mask");
  end

endmodule

// File: rtl/cs_region_pick.sv
module cs_region_pick
  import cs_dec_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int OFF_W  = 28
) (
  input  logic [NUM_CS-1:0]        hits,
  input  logic [NUM_CS*MASK_W-1:0] masks,
  input  logic [OFF_W-1:0]         addr_lo,
  output logic [NUM_CS-1:0]        grant,
  output logic [OFF_W-1:0]         off
);

  localparam int LOW_W = OFF_W - MASK_W;

  logic [MASK_W-1:0] win_mask;

  // Lowest set bit wins
  assign grant = hits & (~hits + {{(NUM_CS-1){1'b0}}, 1'b1});

  always_comb begin
    win_mask = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (grant[i]) win_mask = win_mask | masks[i*MASK_W +: MASK_W];
    end
    if (|grant) off = {addr_lo[OFF_W-1:LOW_W] & ~win_mask, addr_lo[LOW_W-1:0]};
    else        off = '0;
  end

endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 30
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    strobe,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NUM_CS*CFG_W-1:0] cfg_words,
  output logic [NUM_CS-1:0]       cs_sel,
  output logic [ADDR_W-BASE_W+MASK_W-1:0] offset,
  output logic [NUM_CS-1:0]       cs_err
);

  localparam int LOW_W = ADDR_W - BASE_W;
  localparam int OFF_W = LOW_W + MASK_W;

  logic [NUM_CS-1:0]        hit_vec;
  logic [NUM_CS-1:0]        err_vec;
  logic [NUM_CS-1:0]        valid_vec;
  logic [NUM_CS*MASK_W-1:0] mask_vec;
  logic [NUM_CS-1:0]        grant;
  logic [OFF_W-1:0]         off_nxt;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign valid_vec[g] = cfg_words[g*CFG_W + BASE_W];
    cs_region_check u_chk (
      .cfg_word (cfg_words[g*CFG_W +: CFG_W]),
      .addr_hi  (addr[ADDR_W-1:LOW_W]),
      .hit      (hit_vec[g]),
      .err      (err_vec[g]),
      .mask     (mask_vec[g*MASK_W +: MASK_W])
    );
  end

  cs_region_pick #(.NUM_CS(NUM_CS), .OFF_W(OFF_W)) u_pick (
    .hits    (hit_vec),
    .masks   (mask_vec),
    .addr_lo (addr[OFF_W-1:0]),
    .grant   (grant),
    .off     (off_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sel <= '0;
      offset <= '0;
      cs_err <= '0;
    end else begin
      cs_err <= err_vec;
      if (strobe) begin
        cs_sel <= grant;
        offset <= off_nxt;
      end else begin
        cs_sel <= '0;
        offset <= '0;
      end
    end
  end

  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(cs_sel));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (cs_sel == '0 && offset == '0));

  // R4
  disabled_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cs_sel & ~$past(valid_vec)) == '0));

  // R4
  disabled_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cs_err & ~$past(valid_vec)) == '0));

  // R5
  err_blocks_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_sel & cs_err) == '0);

  // R7
  offset_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
    offset[OFF_W-1] == 1'b0);

endmodule

// File: tb/sim_cs_region_decoder.sv
module sim_cs_region_decoder;
  import cs_dec_pkg::*;

  localparam int N = 8;
  localparam int AW = 30;
  localparam int OW = 28;

  typedef struct packed {
    logic          stb;
    logic [AW-1:0] a;
    logic [N-1:0]  sel;
    logic [OW-1:0] off;
  } vec_t;

  // Table config: cs0 0x00/F, cs1 0x02/E, cs2 0x04/C, cs3 0x08/8,
  // cs4 0x10/F, cs5 0x00/F (overlaps cs0), cs6 disabled, cs7 bad mask A
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 30'h0012_3456, 8'h01, 28'h012_3456},  // R3 R7 16 MiB
    '{1'b1, 30'h0200_0010, 8'h02, 28'h000_0010},  // R3 32 MiB low half
    '{1'b1, 30'h0305_0000, 8'h02, 28'h105_0000},  // R7 32 MiB upper half
    '{1'b1, 30'h0600_0004, 8'h04, 28'h200_0004},  // R7 64 MiB
    '{1'b1, 30'h0F00_00FF, 8'h08, 28'h700_00FF},  // R7 128 MiB
    '{1'b1, 30'h1000_0001, 8'h10, 28'h000_0001},  // R3 top base bits
    '{1'b1, 30'h1100_0000, 8'h00, 28'h000_0000},  // R4 disabled cs6
    '{1'b1, 30'h1200_0000, 8'h00, 28'h000_0000},  // R5 bad mask cs7
    '{1'b1, 30'h2000_0000, 8'h00, 28'h000_0000},  // R3 no region
    '{1'b1, 30'h3FFF_FFFF, 8'h00, 28'h000_0000},  // R3 top of space
    '{1'b1, 30'h00FF_FFFF, 8'h01, 28'h0FF_FFFF},  // R8 overlap cs0 over cs5
    '{1'b0, 30'h0012_3456, 8'h00, 28'h000_0000}   // R2 no strobe
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            strobe = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [N*CFG_W-1:0] cfg_words = '0;
  logic [N-1:0]    cs_sel;
  logic [OW-1:0]   offset;
  logic [N-1:0]    cs_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cs_region_decoder #(.NUM_CS(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .strobe(strobe), .addr(addr),
    .cfg_words(cfg_words), .cs_sel(cs_sel), .offset(offset), .cs_err(cs_err)
  );

  function automatic logic [CFG_W-1:0] w(input logic [3:0] m, input logic v,
                                         input logic [5:0] b);
    return {m, 1'b0, v, b};
  endfunction

  task automatic set_cfg(input int i, input logic [CFG_W-1:0] word);
    cfg_words[i*CFG_W +: CFG_W] = word;
  endtask

  // Called at a falling edge: drive, pass one rising edge, check at next falling edge
  task automatic step(input logic s, input logic [AW-1:0] a, input logic [N-1:0] xs,
                      input logic [OW-1:0] xo, input logic [N-1:0] xe, input string req);
    strobe = s;
    addr   = a;
    @(negedge clk);
    n_chk++;
    if (cs_sel !== xs || offset !== xo || cs_err !== xe) begin
      n_bad++;
      $display("FAIL %s addr=%h sel=%h/%h off=%h/%h err=%h/%h (actual/expected)",
               req, a, cs_sel, xs, offset, xo, cs_err, xe);
    end
  endtask

  initial begin
    set_cfg(0, w(4'hF, 1'b1, 6'h00));
    set_cfg(1, w(4'hE, 1'b1, 6'h02));
    set_cfg(2, w(4'hC, 1'b1, 6'h04));
    set_cfg(3, w(4'h8, 1'b1, 6'h08));
    set_cfg(4, w(4'hF, 1'b1, 6'h10));
    set_cfg(5, w(4'hF, 1'b1, 6'h00));
    set_cfg(6, w(4'hF, 1'b0, 6'h11));
    set_cfg(7, w(4'hA, 1'b1, 6'h12));
    strobe = 1'b1;
    addr   = 30'h0012_3456;
    repeat (3) @(negedge clk);
    // R1: reset holds outputs low despite a strobed hit and an error word
    n_chk++;
    if (cs_sel !== '0 || offset !== '0 || cs_err !== '0) begin
      n_bad++;
      $display("FAIL R1 sel=%h off=%h err=%h expected all zero", cs_sel, offset, cs_err);
    end
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].stb, VEC[i].a, VEC[i].sel, VEC[i].off, 8'h80, "R3/R7/R8 table");
    end

    // R6: cs4 base low bit 1 where mask E is clear
    set_cfg(4, w(4'hE, 1'b1, 6'h11));
    step(1'b1, 30'h1000_0000, 8'h00, 28'h0, 8'h90, "R6");

    // R9: restore cs4 in the same cycle as a strobe
    set_cfg(4, w(4'hF, 1'b1, 6'h10));
    step(1'b1, 30'h1000_0000, 8'h10, 28'h0, 8'h80, "R9");

    // R4: disabled cs0 with illegal mask raises no error; cs5 takes over (R8)
    set_cfg(0, w(4'h3, 1'b0, 6'h0F));
    step(1'b1, 30'h0000_0000, 8'h20, 28'h0, 8'h80, "R4");

    // R5: mask 0111 on cs2
    set_cfg(2, w(4'h7, 1'b1, 6'h04));
    step(1'b1, 30'h0600_0004, 8'h00, 28'h0, 8'h84, "R5");

    // R3: reserved bit 7 set changes nothing
    set_cfg(2, w(4'hC, 1'b1, 6'h04) | 12'h080);
    step(1'b1, 30'h0700_0000, 8'h04, 28'h300_0000, 8'h80, "R3 reserved bit");

    // R2: strobe drop after a hit clears outputs
    step(1'b0, 30'h0700_0000, 8'h00, 28'h0, 8'h80, "R2");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule